// File: doc/BRIEF.md
# Manchester Line Receiver with Preamble and Frame-Start Matching

This block takes one serial input carrying Manchester-coded data and returns 8-bit characters. The system clock runs at sixteen times the bit rate, so every bit occupies sixteen consecutive samples. The input is first passed through a two-stage synchronizer. An optional inversion is applied at the same point, so the idle line always reads high inside the block.

A frame has three parts. It may begin with a programmable preamble of 0 to 15 bits, whose pattern is chosen from four fixed shapes. A frame-start delimiter follows, in one of two styles: a single coded zero, or a long sync shape. The data character comes last. The decoder turns the configuration into the sequence of half-bit levels it should see. It locks on the first falling edge that stays low for a quarter bit, and from then on it samples each half-bit near its centre and compares it with that sequence. Once the sequence is complete it decodes the data bits from their mid-bit transitions.

All configuration pins are static and are changed only while the line is idle. The output side has no ready signal, because a serial line cannot be paused. Each character appears as a one-cycle `chr_valid` pulse, and the consumer must take `chr_data` and `chr_err` in that same cycle. There is no back-pressure.

Top module: `manchester_rx`

## Requirements
- R1: While `man_en` is low the decoder stays in its search state and produces no `chr_valid` pulse, even when a complete valid frame is applied to the line.
- R2: A frame start is recognised only when the line, after being high, reads low for 4 consecutive samples (a quarter bit). A low pulse of 3 samples is rejected and produces no output. The next proper frame is still decoded.
- R3: Each bit spans 16 samples. Its first 8 samples carry the complement of the bit value and its last 8 samples carry the value, so a one is low-then-high and a zero is high-then-low. After reset `chr_valid`, `chr_err` and `chr_data` are 0.
- R4: `pre_len` sets the number of preamble bits, from 0 to 15. A value of 0 means no preamble is expected, and the delimiter must follow the start directly.
- R5: `pre_pat` selects the preamble bit pattern: 2'b00 all ones, 2'b01 all zeros, 2'b10 alternating starting with zero, 2'b11 alternating starting with one.
- R6: A half-bit that differs from the expected preamble or delimiter sequence aborts the frame without any `chr_valid` pulse.
- R7: When `inv_pol` is 1 the raw line is complemented before all detection and decoding, so the idle raw line is low.
- R8: With `sfd_one` set to 1, the delimiter is one coded zero bit (high half then low half).
- R9: With `sfd_one` at 0, the delimiter is a sync shape of 24 samples low followed by 24 samples high when `sync_alt` is 0, or 24 high followed by 24 low when `sync_alt` is 1.
- R10: Data is 8 bits sent least significant bit first. After the last bit, `chr_valid` pulses for exactly one cycle with `chr_err` at 0 and the character on `chr_data`.
- R11: If a data bit has the same level in both halves, `chr_valid` pulses with `chr_err` at 1 and the decoder returns to start search. A following good frame is then decoded normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at 16 times the bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| man_en | input | 1 | Manchester decoding enable |
| inv_pol | input | 1 | Complement the line before decoding |
| pre_len | input | 4 | Preamble length in bits, 0 disables the preamble |
| pre_pat | input | 2 | Preamble pattern select |
| sfd_one | input | 1 | 1: one-bit zero delimiter, 0: sync-shape delimiter |
| sync_alt | input | 1 | Selects the complemented sync shape |
| rxd | input | 1 | Serial Manchester line |
| chr_valid | output | 1 | One-cycle pulse marking a finished character |
| chr_data | output | 8 | Decoded character, bit 0 received first |
| chr_err | output | 1 | Missing mid-bit transition in this character |

## Verification
The hardest situations to reach are the ones where the first falling edge is not at a bit boundary. With a zero-first preamble, or with the complemented sync shape, the edge lands in the middle of a bit or after three half-bits of high. A behavioural encoder in the bench builds each frame from the requirements for every preamble length and pattern, with both delimiter styles. Missing-transition errors are produced by replacing a chosen data bit with a constant level and cutting the frame short after it. Preamble mismatches are produced by configuring one pattern and sending another.

// File: rtl/mdec_pkg.sv
package mdec_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_MATCH = 2'd2,
    ST_DATA  = 2'd3
  } mdec_state_e;

  localparam logic [1:0] PAT_ONES  = 2'b00;
  localparam logic [1:0] PAT_ZEROS = 2'b01;
  localparam logic [1:0] PAT_ZO    = 2'b10;
  localparam logic [1:0] PAT_OZ    = 2'b11;
endpackage

// File: rtl/mdec_sync.sv
module mdec_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic inv,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '1;
        else        pipe[0] <= din ^ inv;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-2:0], din ^ inv};
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/mdec_seq.sv
module mdec_seq
  import mdec_pkg::*;
#(
  parameter int PRE_W = 4,
  parameter int IDX_W = 6
) (
  input  logic [PRE_W-1:0] pre_len,
  input  logic [1:0]       pre_pat,
  input  logic             sfd_one,
  input  logic             sync_alt,
  input  logic [IDX_W-1:0] idx,
  output logic             exp_level,
  output logic [IDX_W-1:0] first_zero,
  output logic [IDX_W-1:0] seq_len
);
  logic [IDX_W-1:0] pre_halves;
  logic [IDX_W-1:0] sfd_pos;
  logic             bit_val;

  always_comb begin
    pre_halves = IDX_W'({pre_len, 1'b0});
    seq_len    = pre_halves + (sfd_one ? IDX_W'(2) : IDX_W'(6));
    sfd_pos    = idx - pre_halves;
    bit_val    = 1'b0;
    exp_level  = 1'b1;
    if (idx < pre_halves) begin
      unique case (pre_pat)
        PAT_ONES:  bit_val = 1'b1;
        PAT_ZEROS: bit_val = 1'b0;
        PAT_ZO:    bit_val = idx[1];
        default:   bit_val = ~idx[1];
      endcase
      exp_level = idx[0] ? bit_val : ~bit_val;
    end else if (sfd_one) begin
      exp_level = (sfd_pos == '0);
    end else begin
      exp_level = (sfd_pos < IDX_W'(3)) ? sync_alt : ~sync_alt;
    end

    if (pre_len != '0)
      first_zero = (pre_pat == PAT_ONES || pre_pat == PAT_OZ) ? IDX_W'(0) : IDX_W'(1);
    else if (sfd_one)
      first_zero = IDX_W'(1);
    else
      first_zero = sync_alt ? IDX_W'(3) : IDX_W'(0);
  end
endmodule

// File: rtl/mdec_fsm.sv
module mdec_fsm
  import mdec_pkg::*;
#(
  parameter int SPB    = 16,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              line,
  input  logic              exp_level,
  input  logic [IDX_W-1:0]  first_zero,
  input  logic [IDX_W-1:0]  seq_len,
  output logic [IDX_W-1:0]  idx,
  output logic              chr_valid,
  output logic [DATA_W-1:0] chr_data,
  output logic              chr_err
);
  localparam int HALF   = SPB / 2;
  localparam int QTR    = SPB / 4;
  localparam int CNT_W  = $clog2(HALF);
  localparam int DCNT_W = $clog2(2 * DATA_W);

  mdec_state_e       state;
  logic              prev;
  logic [CNT_W-1:0]  cnt;
  logic [DCNT_W-1:0] dcnt;
  logic              first_half;
  logic [DATA_W-1:0] shreg;
  logic              tick;

  assign tick = (cnt == CNT_W'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      prev       <= 1'b1;
      cnt        <= '0;
      idx        <= '0;
      dcnt       <= '0;
      first_half <= 1'b0;
      shreg      <= '0;
      chr_valid  <= 1'b0;
      chr_err    <= 1'b0;
      chr_data   <= '0;
    end else begin
      prev      <= line;
      chr_valid <= 1'b0;
      chr_err   <= 1'b0;
      if (!en) begin
        state <= ST_IDLE;
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (prev && !line) begin
              state <= ST_START;
              cnt   <= CNT_W'(1);
            end
          end
          ST_START: begin
            if (line) begin
              state <= ST_IDLE;
            end else if (cnt == CNT_W'(QTR - 1)) begin
              cnt   <= '0;
              dcnt  <= '0;
              idx   <= first_zero + IDX_W'(1);
              state <= (first_zero + IDX_W'(1) == seq_len) ? ST_DATA : ST_MATCH;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          ST_MATCH: begin
            if (tick) begin
              cnt <= '0;
              if (line != exp_level) begin
                state <= ST_IDLE;
              end else begin
                idx <= idx + IDX_W'(1);
                if (idx + IDX_W'(1) == seq_len) begin
                  state <= ST_DATA;
                  dcnt  <= '0;
                end
              end
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          default: begin
            if (tick) begin
              cnt  <= '0;
              dcnt <= dcnt + DCNT_W'(1);
              if (!dcnt[0]) begin
                first_half <= line;
              end else if (line == first_half) begin
                chr_valid <= 1'b1;
                chr_err   <= 1'b1;
                chr_data  <= shreg;
                state     <= ST_IDLE;
              end else begin
                shreg <= {line, shreg[DATA_W-1:1]};
                if (dcnt == DCNT_W'(2 * DATA_W - 1)) begin
                  chr_valid <= 1'b1;
                  chr_data  <= {line, shreg[DATA_W-1:1]};
                  state     <= ST_IDLE;
                end
              end
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
        endcase
      end
    end
  end

  // R10: a character strobe lasts exactly one cycle
  p_valid_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    chr_valid |=> !chr_valid);

  // R11: the error flag is only raised together with the strobe
  p_err_with_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    chr_err |-> chr_valid);

  // R1: with decoding disabled the search state is held and nothing is emitted
  p_disabled_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (state == ST_IDLE && !chr_valid));

  // R2: a high sample during start qualification rejects the start
  p_short_low_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state == ST_START && line) |=> state == ST_IDLE);

  // R4: the template position stays inside the configured sequence
  p_idx_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_MATCH |-> idx < seq_len);
endmodule

// File: rtl/manchester_rx.sv
module manchester_rx #(
  parameter int SPB         = 16,
  parameter int DATA_W      = 8,
  parameter int PRE_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              man_en,
  input  logic              inv_pol,
  input  logic [PRE_W-1:0]  pre_len,
  input  logic [1:0]        pre_pat,
  input  logic              sfd_one,
  input  logic              sync_alt,
  input  logic              rxd,
  output logic              chr_valid,
  output logic [DATA_W-1:0] chr_data,
  output logic              chr_err
);
  localparam int MAX_SEQ = 2 * ((1 << PRE_W) - 1) + 6;
  localparam int IDX_W   = $clog2(MAX_SEQ + 1);

  logic             line;
  logic             exp_level;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] first_zero;
  logic [IDX_W-1:0] seq_len;

  mdec_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rxd),
    .inv  (inv_pol),
    .dout (line)
  );

  mdec_seq #(.PRE_W(PRE_W), .IDX_W(IDX_W)) u_seq (
    .pre_len   (pre_len),
    .pre_pat   (pre_pat),
    .sfd_one   (sfd_one),
    .sync_alt  (sync_alt),
    .idx       (idx),
    .exp_level (exp_level),
    .first_zero(first_zero),
    .seq_len   (seq_len)
  );

  mdec_fsm #(.SPB(SPB), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (man_en),
    .line      (line),
    .exp_level (exp_level),
    .first_zero(first_zero),
    .seq_len   (seq_len),
    .idx       (idx),
    .chr_valid (chr_valid),
    .chr_data  (chr_data),
    .chr_err   (chr_err)
  );
endmodule

// File: tb/tb_manchester_rx.sv
`timescale 1ns/1ps
module tb_manchester_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       man_en = 1'b1;
  logic       inv_pol = 1'b0;
  logic [3:0] pre_len = '0;
  logic [1:0] pre_pat = '0;
  logic       sfd_one = 1'b1;
  logic       sync_alt = 1'b0;
  logic       rxd = 1'b1;
  logic       chr_valid;
  logic [7:0] chr_data;
  logic       chr_err;

  int tests = 0;
  int fails = 0;
  int nvalid = 0;
  logic [7:0] got_data;
  logic       got_err;
  bit hv [0:127];
  int nh;

  always #10 clk = ~clk;

  manchester_rx dut (
    .clk(clk), .rst_n(rst_n), .man_en(man_en), .inv_pol(inv_pol),
    .pre_len(pre_len), .pre_pat(pre_pat), .sfd_one(sfd_one), .sync_alt(sync_alt),
    .rxd(rxd), .chr_valid(chr_valid), .chr_data(chr_data), .chr_err(chr_err)
  );

  always @(negedge clk) begin
    if (chr_valid) begin
      nvalid++;
      got_data = chr_data;
      got_err  = chr_err;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk) rxd <= 1'b1 ^ inv_pol;
  endtask

  task automatic set_cfg(input int plen, input int pat, input bit one,
                         input bit alt, input bit inv);
    @(negedge clk);
    pre_len  <= 4'(plen);
    pre_pat  <= 2'(pat);
    sfd_one  <= one;
    sync_alt <= alt;
    inv_pol  <= inv;
    rxd      <= 1'b1 ^ inv;
    idle(8);
  endtask

  task automatic add_bit(input bit v);
    hv[nh] = ~v;
    hv[nh+1] = v;
    nh += 2;
  endtask

  // Behavioural encoder: preamble, delimiter, data (LSB first), optional bad bit
  task automatic send_frame(input int plen, input int pat, input bit one,
                            input bit alt, input logic [7:0] d, input int bad);
    nh = 0;
    nvalid = 0;
    for (int b = 0; b < plen; b++) begin
      case (pat)
        0: add_bit(1'b1);
        1: add_bit(1'b0);
        2: add_bit(b[0]);
        default: add_bit(!b[0]);
      endcase
    end
    if (one) add_bit(1'b0);
    else begin
      for (int k = 0; k < 3; k++) begin hv[nh] = alt; nh++; end
      for (int k = 0; k < 3; k++) begin hv[nh] = !alt; nh++; end
    end
    for (int i = 0; i < 8; i++) begin
      if (i == bad) begin
        hv[nh] = 1'b1; hv[nh+1] = 1'b1; nh += 2;
        break;
      end
      add_bit(d[i]);
    end
    idle(12);
    for (int h = 0; h < nh; h++)
      repeat (8) @(negedge clk) rxd <= hv[h] ^ inv_pol;
    idle(40);
  endtask

  task automatic expect_char(input string req, input logic [7:0] d);
    check(nvalid == 1, req, "strobe count", nvalid, 1);
    check(got_data == d, req, "data", int'(got_data), int'(d));
    check(got_err == 1'b0, req, "err flag", int'(got_err), 0);
  endtask

  task automatic t_reset;
    check(chr_valid == 1'b0, "R3", "reset valid", int'(chr_valid), 0);
    check(chr_err == 1'b0, "R3", "reset err", int'(chr_err), 0);
    check(chr_data == 8'h00, "R3", "reset data", int'(chr_data), 0);
  endtask

  task automatic t_basic;
    logic [7:0] vals [4] = '{8'hA5, 8'h00, 8'hFF, 8'h3C};
    set_cfg(0, 0, 1'b1, 1'b0, 1'b0);
    foreach (vals[i]) begin
      send_frame(0, 0, 1'b1, 1'b0, vals[i], -1);
      expect_char("R10", vals[i]);
    end
  endtask

  task automatic t_all_preambles;
    for (int l = 0; l < 16; l++)
      for (int p = 0; p < 4; p++) begin
        logic [7:0] d;
        d = 8'(l * 16 + p * 5 + 1);
        set_cfg(l, p, 1'b1, 1'b0, 1'b0);
        send_frame(l, p, 1'b1, 1'b0, d, -1);
        expect_char("R4 R5 R8", d);
      end
  endtask

  task automatic t_sync;
    for (int a = 0; a < 2; a++)
      for (int l = 0; l < 3; l++) begin
        logic [7:0] d;
        d = 8'(8'h96 ^ (a * 8'h11) ^ l);
        set_cfg(l, l, 1'b0, a[0], 1'b0);
        send_frame(l, l, 1'b0, a[0], d, -1);
        expect_char("R9", d);
      end
  endtask

  task automatic t_polarity;
    set_cfg(3, 2, 1'b0, 1'b1, 1'b1);
    send_frame(3, 2, 1'b0, 1'b1, 8'hC3, -1);
    expect_char("R7", 8'hC3);
    set_cfg(2, 0, 1'b1, 1'b0, 1'b1);
    send_frame(2, 0, 1'b1, 1'b0, 8'h5E, -1);
    expect_char("R7", 8'h5E);
  endtask

  task automatic t_disabled;
    set_cfg(0, 0, 1'b1, 1'b0, 1'b0);
    man_en <= 1'b0;
    send_frame(0, 0, 1'b1, 1'b0, 8'h77, -1);
    check(nvalid == 0, "R1", "strobes while disabled", nvalid, 0);
    man_en <= 1'b1;
    idle(8);
    send_frame(0, 0, 1'b1, 1'b0, 8'h77, -1);
    expect_char("R1", 8'h77);
  endtask

  task automatic t_short_start;
    set_cfg(0, 0, 1'b0, 1'b0, 1'b0);
    nvalid = 0;
    repeat (3) @(negedge clk) rxd <= 1'b0;
    idle(60);
    check(nvalid == 0, "R2", "strobes after short low", nvalid, 0);
    send_frame(0, 0, 1'b0, 1'b0, 8'h2B, -1);
    expect_char("R2", 8'h2B);
  endtask

  task automatic t_mismatch;
    set_cfg(4, 0, 1'b1, 1'b0, 1'b0);
    send_frame(4, 1, 1'b1, 1'b0, 8'h00, -1);
    check(nvalid == 0, "R6", "strobes on wrong preamble", nvalid, 0);
    send_frame(4, 0, 1'b1, 1'b0, 8'h81, -1);
    expect_char("R6", 8'h81);
  endtask

  task automatic t_manerr;
    set_cfg(0, 0, 1'b0, 1'b0, 1'b0);
    send_frame(0, 0, 1'b0, 1'b0, 8'h5A, 3);
    check(nvalid == 1, "R11", "strobe on bad bit", nvalid, 1);
    check(got_err == 1'b1, "R11", "err flag", int'(got_err), 1);
    send_frame(0, 0, 1'b0, 1'b0, 8'hE4, -1);
    expect_char("R11", 8'hE4);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n <= 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_all_preambles();
    t_sync();
    t_polarity();
    t_disabled();
    t_short_start();
    t_mismatch();
    t_manerr();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule